// File: doc/BRIEF.md
# Field-Described Control Register Bank with AXI4-Lite Access

This block is a small bank of 32-bit control and status words that a processor reaches over AXI4-Lite. A bridge turns each AXI4-Lite transaction into a single-cycle access on a simple internal word-addressed bus. The bank behind it is assembled from a table of field descriptors. Each descriptor gives the word, the lowest bit, the width, the access mode and the reset value. Fields are packed upward from bit 0 of their word.

Four access modes exist. A constant or status field mirrors an internal input. A setting field holds what software writes and drives internal logic. An event flag is set by an internal pulse, holds its value, and clears when its word is read. A command bit emits a one-cycle strobe when software writes a 1 to it. The event flags of the event word are ORed into one interrupt line. The internal bus uses word indices, so byte address = word index × 4.

Word map (byte offsets): 0x00 identifier; 0x04 version; 0x08 control; 0x0C events; 0x10 command; 0x14 status; 0x18 and 0x1C are unmapped.

Top module: `field_regbank`

## Requirements
- R1: After reset: `core_hold_o` = 1, `scale_o` = 0x10, `narrow_o` = 0, `go_o` = `halt_o` = 0 and `irq_o` = 0. The control word at 0x08 reads 0x0000_1001 and the event word at 0x0C reads 0.
- R2: 0x00 reads the `ID_WORD` parameter (default 0x6169616d). 0x04 reads bugfix in bits 7:0, minor in bits 15:8, major in bits 23:16 and platform in bits 31:24. With the defaults this gives 0x0001_0203.
- R3: Setting fields keep the written value, read it back and drive their outputs. These are hold in bit 0 of 0x08 (`core_hold_o`), scale in bits 15:8 of 0x08 (`scale_o`) and narrow in bit 2 of 0x10 (`narrow_o`). A bit changes only when `s_wstrb` enables its byte lane.
- R4: Read-only fields ignore writes. 0x14 reads `status_word`, and bit 3 of 0x10 reads `overrun_in`.
- R5: Event flags sit in bit 0 (`ev_in[0]`) and bit 1 (`ev_in[1]`) of 0x0C. A flag becomes 1 on the clock edge where its input is 1 and stays 1 after the input drops. A read of 0x0C returns the flags and clears them. Writes to 0x0C have no effect.
- R6: If an event input is 1 on the same edge that a read of 0x0C is accepted, the flag stays 1 and the next read returns it.
- R7: `irq_o` is 1 exactly while any event flag is 1.
- R8: Writing 1 to bit 0 (go) or bit 1 (halt) of 0x10, with byte lane 0 enabled, drives `go_o` or `halt_o` high for exactly one cycle. That cycle is the one in which `s_bvalid` first rises. These bits read as 0.
- R9: Word addresses 0x18 and 0x1C read 0 with response OKAY. Writes to them change no mapped field.
- R10: AW and W may arrive in either order or together. Each write gets exactly one B response with `s_bresp` = 0 (OKAY), held until `s_bready`.
- R11: `s_rvalid` rises on the cycle after the AR handshake. `s_rdata` stays stable until `s_rready`, `s_rresp` = 0, and `s_arready` is low while `s_rvalid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_awaddr | input | ADDR_W+2 | Write byte address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte-lane enables |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response, always OKAY |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W+2 | Read byte address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response, always OKAY |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| status_word | input | 32 | Value shown at 0x14 |
| overrun_in | input | 1 | Value shown at bit 3 of 0x10 |
| ev_in | input | 2 | Event set pulses |
| core_hold_o | output | 1 | Hold control, resets to 1 |
| scale_o | output | 8 | Scale setting |
| narrow_o | output | 1 | Narrow-mode setting |
| go_o | output | 1 | Go command strobe |
| halt_o | output | 1 | Halt command strobe |
| irq_o | output | 1 | Aggregate event interrupt |

## Verification
The assertions rely on AXI4-Lite manager rules. A valid held high stays high until its handshake, with its payload steady, and the ready signals are free to stall at any time. The one-cycle strobe property also relies on the bridge never committing two writes on back-to-back cycles. The bench drives every channel on the falling edge and keeps each valid and payload until the handshake. It delays `s_bready` and `s_rready` to exercise back-pressure, and it raises event inputs for exactly one cycle so that the set and clear edges are known.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  localparam int DATA_W = 32;
  localparam int STRB_W = DATA_W / 8;

  typedef enum logic [1:0] {FM_RO, FM_RW, FM_STICKY, FM_PULSE} fmode_e;

  typedef struct packed {
    logic [7:0]        word;
    logic [4:0]        lsb;
    logic [5:0]        width;
    fmode_e            mode;
    logic [DATA_W-1:0] rstv;
  } fdesc_t;

  function automatic fdesc_t mkf(int w, int l, int n, fmode_e m, logic [DATA_W-1:0] r);
    fdesc_t d;
    d.word = 8'(w); d.lsb = 5'(l); d.width = 6'(n); d.mode = m; d.rstv = r;
    return d;
  endfunction

  localparam int NFIELD   = 14;
  localparam int IRQ_WORD = 3;
  localparam int F_ID = 0, F_BUG = 1, F_MIN = 2, F_MAJ = 3, F_PLAT = 4;
  localparam int F_HOLD = 5, F_SCALE = 6, F_EVA = 7, F_EVB = 8;
  localparam int F_GO = 9, F_HALT = 10, F_NARROW = 11, F_OVR = 12, F_STAT = 13;

  localparam fdesc_t FIELDS [NFIELD] = '{
    mkf(0, 0, 32, FM_RO, '0),
    mkf(1, 0, 8, FM_RO, '0),
    mkf(1, 8, 8, FM_RO, '0),
    mkf(1, 16, 8, FM_RO, '0),
    mkf(1, 24, 8, FM_RO, '0),
    mkf(2, 0, 1, FM_RW, 32'h1),
    mkf(2, 8, 8, FM_RW, 32'h10),
    mkf(3, 0, 1, FM_STICKY, '0),
    mkf(3, 1, 1, FM_STICKY, '0),
    mkf(4, 0, 1, FM_PULSE, '0),
    mkf(4, 1, 1, FM_PULSE, '0),
    mkf(4, 2, 1, FM_RW, '0),
    mkf(4, 3, 1, FM_RO, '0),
    mkf(5, 0, 32, FM_RO, '0)
  };
endpackage

// File: rtl/rb_field.sv
module rb_field
  import regbank_pkg::*;
#(
  parameter int              W    = 1,
  parameter int              LSB  = 0,
  parameter fmode_e          MODE = FM_RW,
  parameter logic [DATA_W-1:0] RSTV = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] wmask,
  input  logic              rd_hit,
  input  logic [DATA_W-1:0] hw_in,
  output logic [DATA_W-1:0] value,
  output logic [DATA_W-1:0] rd_word
);
  logic [W-1:0] d_slice, m_slice, rdv;

  assign d_slice = wdata[LSB +: W];
  assign m_slice = wmask[LSB +: W];

  generate
    if (MODE == FM_RW) begin : g_rw
      logic [W-1:0] q;
      always_ff @(posedge clk) begin
        if (!rst_n)      q <= RSTV[W-1:0];
        else if (wr_hit) q <= (q & ~m_slice) | (d_slice & m_slice);
      end
      assign rdv   = q;
      assign value = DATA_W'(q);
    end else if (MODE == FM_STICKY) begin : g_sticky
      logic [W-1:0] q;
      always_ff @(posedge clk) begin
        if (!rst_n) q <= RSTV[W-1:0];
        else        q <= (rd_hit ? '0 : q) | hw_in[W-1:0];
      end
      assign rdv   = q;
      assign value = DATA_W'(q);
    end else if (MODE == FM_PULSE) begin : g_pulse
      logic [W-1:0] q;
      always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= wr_hit ? (d_slice & m_slice) : '0;
      end
      assign rdv   = '0;
      assign value = DATA_W'(q);
    end else begin : g_ro
      assign rdv   = hw_in[W-1:0];
      assign value = DATA_W'(hw_in[W-1:0]);
    end
  endgenerate

  assign rd_word = DATA_W'(rdv) << LSB;

  logic unused_sink;
  assign unused_sink = ^{wdata, wmask, hw_in, rd_hit, wr_hit, d_slice, m_slice};
endmodule

// File: rtl/rb_core.sv
module rb_core
  import regbank_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [STRB_W-1:0] wstrb,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata,
  input  logic [DATA_W-1:0] hw_in [NFIELD],
  output logic [DATA_W-1:0] fval  [NFIELD],
  output logic              irq
);
  logic [DATA_W-1:0] wmask;
  logic [DATA_W-1:0] rd_words [NFIELD];
  logic [NFIELD-1:0] irq_bits;
  logic [DATA_W-1:0] rd_next;

  for (genvar b = 0; b < STRB_W; b++) begin : g_lane
    assign wmask[8*b +: 8] = {8{wstrb[b]}};
  end

  for (genvar i = 0; i < NFIELD; i++) begin : g_fld
    localparam int WRD = int'(FIELDS[i].word);
    logic whit, rhit;
    assign whit = wr_en && (waddr == ADDR_W'(WRD));
    assign rhit = rd_en && (raddr == ADDR_W'(WRD));
    rb_field #(
      .W(int'(FIELDS[i].width)),
      .LSB(int'(FIELDS[i].lsb)),
      .MODE(FIELDS[i].mode),
      .RSTV(FIELDS[i].rstv)
    ) u_field (
      .clk(clk), .rst_n(rst_n), .wr_hit(whit), .wdata(wdata), .wmask(wmask),
      .rd_hit(rhit), .hw_in(hw_in[i]), .value(fval[i]), .rd_word(rd_words[i])
    );
    if (FIELDS[i].mode == FM_STICKY && WRD == IRQ_WORD) begin : g_irq
      assign irq_bits[i] = |fval[i];
    end else begin : g_noirq
      assign irq_bits[i] = 1'b0;
    end
  end

  always_comb begin
    rd_next = '0;
    for (int i = 0; i < NFIELD; i++) begin
      if (raddr == ADDR_W'(int'(FIELDS[i].word))) rd_next = rd_next | rd_words[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_next;
  end

  assign irq = |irq_bits;
endmodule

// File: rtl/axil_bridge.sv
module axil_bridge
  import regbank_pkg::*;
#(
  parameter int ADDR_W = 3,
  localparam int AW = ADDR_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     s_awaddr,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [DATA_W-1:0] s_wdata,
  input  logic [STRB_W-1:0] s_wstrb,
  input  logic              s_wvalid,
  output logic              s_wready,
  output logic [1:0]        s_bresp,
  output logic              s_bvalid,
  input  logic              s_bready,
  input  logic [AW-1:0]     s_araddr,
  input  logic              s_arvalid,
  output logic              s_arready,
  output logic [DATA_W-1:0] s_rdata,
  output logic [1:0]        s_rresp,
  output logic              s_rvalid,
  input  logic              s_rready,
  output logic              nb_wr,
  output logic [ADDR_W-1:0] nb_waddr,
  output logic [DATA_W-1:0] nb_wdata,
  output logic [STRB_W-1:0] nb_wstrb,
  output logic              nb_rd,
  output logic [ADDR_W-1:0] nb_raddr,
  input  logic [DATA_W-1:0] nb_rdata
);
  logic              aw_full, w_full, bvalid_q, rvalid_q;
  logic [ADDR_W-1:0] aw_q;
  logic [DATA_W-1:0] w_q;
  logic [STRB_W-1:0] ws_q;
  logic              commit;

  assign s_awready = !aw_full;
  assign s_wready  = !w_full;
  assign commit    = aw_full && w_full && !bvalid_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      aw_full <= 1'b0; w_full <= 1'b0; bvalid_q <= 1'b0;
      aw_q <= '0; w_q <= '0; ws_q <= '0;
    end else begin
      if (s_awvalid && !aw_full) begin
        aw_full <= 1'b1;
        aw_q    <= s_awaddr[AW-1:2];
      end
      if (s_wvalid && !w_full) begin
        w_full <= 1'b1;
        w_q    <= s_wdata;
        ws_q   <= s_wstrb;
      end
      if (commit) begin
        aw_full  <= 1'b0;
        w_full   <= 1'b0;
        bvalid_q <= 1'b1;
      end else if (bvalid_q && s_bready) begin
        bvalid_q <= 1'b0;
      end
    end
  end

  assign nb_wr    = commit;
  assign nb_waddr = aw_q;
  assign nb_wdata = w_q;
  assign nb_wstrb = ws_q;
  assign s_bvalid = bvalid_q;
  assign s_bresp  = 2'b00;

  assign s_arready = !rvalid_q;
  assign nb_rd     = s_arvalid && !rvalid_q;
  assign nb_raddr  = s_araddr[AW-1:2];

  always_ff @(posedge clk) begin
    if (!rst_n)                  rvalid_q <= 1'b0;
    else if (nb_rd)              rvalid_q <= 1'b1;
    else if (rvalid_q && s_rready) rvalid_q <= 1'b0;
  end

  assign s_rvalid = rvalid_q;
  assign s_rdata  = nb_rdata;
  assign s_rresp  = 2'b00;

  logic unused_lo;
  assign unused_lo = ^{s_awaddr[1:0], s_araddr[1:0]};
endmodule

// File: rtl/field_regbank.sv
module field_regbank
  import regbank_pkg::*;
#(
  parameter int          ADDR_W       = 3,
  parameter logic [31:0] ID_WORD      = 32'h6169616d,
  parameter logic [7:0]  VER_MAJOR    = 8'd1,
  parameter logic [7:0]  VER_MINOR    = 8'd2,
  parameter logic [7:0]  VER_BUGFIX   = 8'd3,
  parameter logic [7:0]  VER_PLATFORM = 8'd0,
  localparam int AXI_AW = ADDR_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AXI_AW-1:0] s_awaddr,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [31:0]       s_wdata,
  input  logic [3:0]        s_wstrb,
  input  logic              s_wvalid,
  output logic              s_wready,
  output logic [1:0]        s_bresp,
  output logic              s_bvalid,
  input  logic              s_bready,
  input  logic [AXI_AW-1:0] s_araddr,
  input  logic              s_arvalid,
  output logic              s_arready,
  output logic [31:0]       s_rdata,
  output logic [1:0]        s_rresp,
  output logic              s_rvalid,
  input  logic              s_rready,
  input  logic [31:0]       status_word,
  input  logic              overrun_in,
  input  logic [1:0]        ev_in,
  output logic              core_hold_o,
  output logic [7:0]        scale_o,
  output logic              narrow_o,
  output logic              go_o,
  output logic              halt_o,
  output logic              irq_o
);
  logic              nb_wr, nb_rd;
  logic [ADDR_W-1:0] nb_waddr, nb_raddr;
  logic [DATA_W-1:0] nb_wdata, nb_rdata;
  logic [STRB_W-1:0] nb_wstrb;
  logic [DATA_W-1:0] hw_in [NFIELD];
  logic [DATA_W-1:0] fval  [NFIELD];

  axil_bridge #(.ADDR_W(ADDR_W)) u_bridge (
    .clk(clk), .rst_n(rst_n),
    .s_awaddr(s_awaddr), .s_awvalid(s_awvalid), .s_awready(s_awready),
    .s_wdata(s_wdata), .s_wstrb(s_wstrb), .s_wvalid(s_wvalid), .s_wready(s_wready),
    .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready),
    .s_araddr(s_araddr), .s_arvalid(s_arvalid), .s_arready(s_arready),
    .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rvalid(s_rvalid), .s_rready(s_rready),
    .nb_wr(nb_wr), .nb_waddr(nb_waddr), .nb_wdata(nb_wdata), .nb_wstrb(nb_wstrb),
    .nb_rd(nb_rd), .nb_raddr(nb_raddr), .nb_rdata(nb_rdata)
  );

  always_comb begin
    for (int i = 0; i < NFIELD; i++) hw_in[i] = '0;
    hw_in[F_ID]   = ID_WORD;
    hw_in[F_BUG]  = DATA_W'(VER_BUGFIX);
    hw_in[F_MIN]  = DATA_W'(VER_MINOR);
    hw_in[F_MAJ]  = DATA_W'(VER_MAJOR);
    hw_in[F_PLAT] = DATA_W'(VER_PLATFORM);
    hw_in[F_EVA]  = DATA_W'(ev_in[0]);
    hw_in[F_EVB]  = DATA_W'(ev_in[1]);
    hw_in[F_OVR]  = DATA_W'(overrun_in);
    hw_in[F_STAT] = status_word;
  end

  rb_core #(.ADDR_W(ADDR_W)) u_core (
    .clk(clk), .rst_n(rst_n),
    .wr_en(nb_wr), .waddr(nb_waddr), .wdata(nb_wdata), .wstrb(nb_wstrb),
    .rd_en(nb_rd), .raddr(nb_raddr), .rdata(nb_rdata),
    .hw_in(hw_in), .fval(fval), .irq(irq_o)
  );

  assign core_hold_o = fval[F_HOLD][0];
  assign scale_o     = fval[F_SCALE][7:0];
  assign narrow_o    = fval[F_NARROW][0];
  assign go_o        = fval[F_GO][0];
  assign halt_o      = fval[F_HALT][0];

  logic unused_fv;
  assign unused_fv = ^{fval[F_ID], fval[F_BUG], fval[F_MIN], fval[F_MAJ], fval[F_PLAT],
                       fval[F_EVA], fval[F_EVB], fval[F_OVR], fval[F_STAT],
                       fval[F_HOLD][31:1], fval[F_SCALE][31:8], fval[F_NARROW][31:1],
                       fval[F_GO][31:1], fval[F_HALT][31:1]};
endmodule

// File: rtl/field_regbank_chk.sv
module field_regbank_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       s_arvalid,
  input logic       s_arready,
  input logic       s_rvalid,
  input logic       s_rready,
  input logic [31:0] s_rdata,
  input logic       s_bvalid,
  input logic       s_bready,
  input logic [1:0] ev_in,
  input logic       irq_o,
  input logic       go_o,
  input logic       halt_o
);
  // R10
  bresp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_bvalid && !s_bready |=> s_bvalid);
  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_rvalid && !s_rready |=> s_rvalid && $stable(s_rdata));
  // R11
  ar_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_rvalid |-> !s_arready);
  // R8
  go_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_o |=> !go_o);
  // R8
  halt_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt_o |=> !halt_o);
  // R6
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_in != 2'b00 |=> irq_o);
  // R5
  clear_by_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_o) |-> $past(s_arvalid && s_arready));
endmodule

bind field_regbank field_regbank_chk u_chk (
  .clk(clk), .rst_n(rst_n), .s_arvalid(s_arvalid), .s_arready(s_arready),
  .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rdata(s_rdata),
  .s_bvalid(s_bvalid), .s_bready(s_bready), .ev_in(ev_in), .irq_o(irq_o),
  .go_o(go_o), .halt_o(halt_o)
);

// File: tb/field_regbank_test.sv
module field_regbank_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [4:0] s_awaddr = '0, s_araddr = '0;
  logic s_awvalid = 0, s_wvalid = 0, s_bready = 0, s_arvalid = 0, s_rready = 0;
  logic [31:0] s_wdata = '0, status_word = '0;
  logic [3:0] s_wstrb = '0;
  logic overrun_in = 0;
  logic [1:0] ev_in = '0;
  logic s_awready, s_wready, s_bvalid, s_arready, s_rvalid;
  logic [1:0] s_bresp, s_rresp;
  logic [31:0] s_rdata;
  logic core_hold_o, narrow_o, go_o, halt_o, irq_o;
  logic [7:0] scale_o;

  int checks = 0, errors = 0, go_cnt = 0, halt_cnt = 0;
  bit done = 0;
  logic seen_go, seen_halt, after_go, after_halt;

  field_regbank uut (.*);

  always #2 clk = ~clk;
  always @(negedge clk) begin
    go_cnt   += int'(go_o);
    halt_cnt += int'(halt_o);
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic axi_write(logic [4:0] a, logic [31:0] d, logic [3:0] st, int order, int bdelay);
    bit aw_done = 0, w_done = 0, ha, hw;
    @(negedge clk);
    s_awaddr = a; s_wdata = d; s_wstrb = st;
    s_awvalid = (order != 2); s_wvalid = (order != 1);
    while (!(aw_done && w_done)) begin
      ha = s_awvalid && s_awready;
      hw = s_wvalid && s_wready;
      @(negedge clk);
      if (ha) begin s_awvalid = 0; aw_done = 1; if (!w_done && !hw) s_wvalid = 1; end
      if (hw) begin s_wvalid = 0; w_done = 1; if (!aw_done && !ha) s_awvalid = 1; end
    end
    while (!s_bvalid) @(negedge clk);
    seen_go = go_o; seen_halt = halt_o;
    chk("R10", "bresp", 32'(s_bresp), 0);
    for (int k = 0; k < bdelay; k++) begin
      @(negedge clk);
      chk("R10", "bvalid held", 32'(s_bvalid), 1);
    end
    s_bready = 1;
    @(negedge clk);
    s_bready = 0;
    after_go = go_o; after_halt = halt_o;
    chk("R10", "single B", 32'(s_bvalid), 0);
  endtask

  task automatic axi_read(logic [4:0] a, int rdelay, output logic [31:0] d);
    logic [31:0] first;
    @(negedge clk);
    s_araddr = a; s_arvalid = 1;
    while (!s_arready) @(negedge clk);
    @(negedge clk);
    s_arvalid = 0;
    chk("R11", "rvalid next cycle", 32'(s_rvalid), 1);
    chk("R11", "arready low", 32'(s_arready), 0);
    first = s_rdata;
    for (int k = 0; k < rdelay; k++) begin
      @(negedge clk);
      chk("R11", "rdata stable", s_rdata, first);
    end
    d = s_rdata;
    chk("R11", "rresp", 32'(s_rresp), 0);
    s_rready = 1;
    @(negedge clk);
    s_rready = 0;
  endtask

  task automatic pulse_ev(logic [1:0] v);
    @(negedge clk); ev_in = v;
    @(negedge clk); ev_in = '0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1", "core_hold", 32'(core_hold_o), 1);
    chk("R1", "scale", 32'(scale_o), 32'h10);
    chk("R1", "narrow", 32'(narrow_o), 0);
    chk("R1", "strobes", {go_o, halt_o}, 0);
    chk("R1", "irq", 32'(irq_o), 0);
    axi_read(5'h08, 0, d); chk("R1", "control word", d, 32'h0000_1001);
    axi_read(5'h0C, 0, d); chk("R1", "event word", d, 0);
  endtask

  task automatic t_ident();
    logic [31:0] d;
    axi_read(5'h00, 0, d); chk("R2", "id", d, 32'h6169616d);
    axi_read(5'h04, 2, d); chk("R2", "version", d, 32'h0001_0203);
  endtask

  task automatic t_settings();
    logic [31:0] d;
    axi_write(5'h08, 32'h0000_5A00, 4'b0011, 0, 0);
    chk("R3", "hold cleared", 32'(core_hold_o), 0);
    chk("R3", "scale", 32'(scale_o), 32'h5A);
    axi_write(5'h08, 32'hFFFF_FF01, 4'b0001, 1, 2);
    chk("R3", "lane0 only hold", 32'(core_hold_o), 1);
    chk("R3", "lane1 masked scale", 32'(scale_o), 32'h5A);
    axi_read(5'h08, 0, d); chk("R3", "readback", d, 32'h0000_5A01);
    axi_write(5'h10, 32'h4, 4'b0001, 2, 0);
    chk("R3", "narrow", 32'(narrow_o), 1);
    chk("R8", "no go when bit0 is 0", 32'(seen_go), 0);
  endtask

  task automatic t_readonly();
    logic [31:0] d;
    status_word = 32'hCAFE_F00D; overrun_in = 1;
    axi_write(5'h00, 32'h0, 4'hF, 0, 0);
    axi_read(5'h00, 0, d); chk("R4", "id after write", d, 32'h6169616d);
    axi_write(5'h14, 32'h1234_5678, 4'hF, 0, 0);
    axi_read(5'h14, 0, d); chk("R4", "status", d, 32'hCAFE_F00D);
    axi_read(5'h10, 0, d); chk("R4", "overrun bit3 + narrow", d, 32'h0000_000C);
    overrun_in = 0;
  endtask

  task automatic t_sticky();
    logic [31:0] d;
    pulse_ev(2'b10);
    chk("R7", "irq on flag", 32'(irq_o), 1);
    repeat (3) @(negedge clk);
    chk("R5", "flag held, irq", 32'(irq_o), 1);
    axi_read(5'h0C, 1, d); chk("R5", "flags read", d, 32'h2);
    chk("R7", "irq after clear", 32'(irq_o), 0);
    axi_read(5'h0C, 0, d); chk("R5", "cleared", d, 0);
    axi_write(5'h0C, 32'h3, 4'hF, 0, 0);
    chk("R5", "write ignored irq", 32'(irq_o), 0);
    axi_read(5'h0C, 0, d); chk("R5", "write ignored", d, 0);
  endtask

  task automatic t_setwins();
    logic [31:0] d;
    pulse_ev(2'b01);
    @(negedge clk);
    s_araddr = 5'h0C; s_arvalid = 1; ev_in = 2'b01;
    @(negedge clk);
    s_arvalid = 0; ev_in = 0;
    chk("R6", "read value", s_rdata, 32'h1);
    chk("R6", "irq kept", 32'(irq_o), 1);
    s_rready = 1; @(negedge clk); s_rready = 0;
    axi_read(5'h0C, 0, d); chk("R6", "event kept", d, 32'h1);
    axi_read(5'h0C, 0, d); chk("R6", "then cleared", d, 0);
  endtask

  task automatic t_pulse();
    logic [31:0] d;
    int g0, h0;
    g0 = go_cnt; h0 = halt_cnt;
    axi_write(5'h10, 32'h5, 4'b0001, 0, 1);
    chk("R8", "go with bvalid", 32'(seen_go), 1);
    chk("R8", "go gone after", 32'(after_go), 0);
    chk("R8", "halt idle", 32'(seen_halt), 0);
    chk("R8", "go one cycle", 32'(go_cnt - g0), 1);
    axi_write(5'h10, 32'h6, 4'b0001, 1, 0);
    chk("R8", "halt with bvalid", 32'(seen_halt), 1);
    chk("R8", "halt one cycle", 32'(halt_cnt - h0), 1);
    axi_write(5'h10, 32'h1, 4'b0000, 2, 0);
    chk("R8", "masked lane no go", 32'(go_cnt - g0), 1);
    axi_read(5'h10, 0, d); chk("R8", "strobe bits read 0", d, 32'h4);
    chk("R3", "narrow kept", 32'(narrow_o), 1);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    axi_write(5'h18, 32'hFFFF_FFFF, 4'hF, 0, 0);
    axi_write(5'h1C, 32'hFFFF_FFFF, 4'hF, 1, 0);
    axi_read(5'h18, 0, d); chk("R9", "0x18 reads 0", d, 0);
    axi_read(5'h1C, 0, d); chk("R9", "0x1C reads 0", d, 0);
    axi_read(5'h08, 0, d); chk("R9", "control untouched", d, 32'h0000_5A01);
    chk("R9", "no strobes", 32'(go_cnt + halt_cnt), 2);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_ident();
    t_settings();
    t_readonly();
    t_sticky();
    t_setwins();
    t_pulse();
    t_unmapped();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule